// File: doc/BRIEF.md
# Calendar-Free Time-of-Day Counter with Snapshot Registers

This block keeps elapsed time as five byte-wide registers: seconds, minutes, hours, a low day byte, and a control byte. The control byte holds the ninth day bit in bit 0 and a day-wrap flag in bit 7. A one-cycle `tick_en` pulse, produced elsewhere once per second, advances the count. The carry ripples through seconds, minutes and hours, then into the day byte. When the 9-bit day value overflows, the wrap flag in bit 7 toggles.

A second set of five registers holds a frozen snapshot, and the read port sees only this set. Software pulses `snap_stb` to copy the running count into the snapshot in a single cycle. It then reads a coherent time value, even while the count keeps moving.

A host write targets one register index and places the byte in both the running and the snapshot copy. The same write path sets the time and clears or sets the wrap flag.

Top module: `rtc_shadow_clock`

## Requirements
- R1: After reset every running and snapshot register is 0, so every readable index (0 to 4) returns 8'h00.
- R2: A tick raises seconds (index 0) by one. When seconds is 59 at the tick, it becomes 0 and minutes (index 1) rises by one.
- R3: When minutes is 59 and a carry arrives from seconds, minutes becomes 0 and hours (index 2) rises by one.
- R4: When hours is 23 and a carry arrives from minutes, hours becomes 0 in that same cycle and the low day byte (index 3) rises by one.
- R5: When the low day byte is 8'hFF and a carry arrives, it becomes 0. If bit 0 of the control byte (index 4) is clear, that bit is set.
- R6: When bit 0 of the control byte is already set and a day carry arrives, bit 0 clears, bit 7 inverts and bits 6..1 keep their value.
- R7: Without a tick or a write, the running registers keep their value over any number of cycles.
- R8: A snapshot strobe copies all five running registers into the snapshot set at the next clock edge. The read port returns snapshot contents only, so ticks between strobes do not change what is read.
- R9: A write with `wr_en` high and `wr_sel` in 0..4 loads `wr_data` into both the running and the snapshot register of that index.
- R10: When a write and a tick occur in the same cycle, the written index takes `wr_data`. The other indices advance as the tick dictates, using carries from the pre-write values.
- R11: When a write and a snapshot strobe occur in the same cycle, the snapshot of the written index takes `wr_data`. The other snapshot indices take the running values.
- R12: `wr_sel` values 5..7 change no register, and `rd_sel` values 5..7 read 8'hFF.
- R13: Seconds, minutes and hours values at or above their limit (for example seconds written as 60..255) count up by one per carry-in without carrying onward, and 8'hFF wraps to 0 without a carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-cycle pulse: advance the count by one second |
| snap_stb | input | 1 | One-cycle pulse: copy running registers into the snapshot set |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Register index for the write (0 sec, 1 min, 2 hour, 3 day low, 4 control) |
| wr_data | input | 8 | Byte to write |
| rd_sel | input | 3 | Register index for the read |
| rd_data | output | 8 | Snapshot byte at `rd_sel`, or 8'hFF for an unused index |

## Verification
The hardest state to reach from the ports is the full carry ripple. It needs 59 seconds, 59 minutes, hour 23, day byte 8'hFF and a chosen control byte all at one tick, and it would take millions of ticks to reach by counting. The bench uses host writes to preset every stage, applies one tick, and then strobes the snapshot so the result can be read. It sweeps each stage's value over all 256 codes, including the control byte, while the stages below it sit at their limits. It also runs one natural two-tick rollover from 58 seconds to confirm the preset path and the counting path agree.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int RTC_REGS = 5;
  localparam int SEL_W    = 3;

  typedef enum logic [SEL_W-1:0] {
    RSEL_SEC   = 3'd0,
    RSEL_MIN   = 3'd1,
    RSEL_HOUR  = 3'd2,
    RSEL_DAYLO = 3'd3,
    RSEL_CTRL  = 3'd4
  } rtc_sel_e;

  localparam int CTRL_DAYHI_BIT = 0;
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/rtc_mod_stage.sv
module rtc_mod_stage #(
  parameter int W     = 8,
  parameter int LIMIT = 60
) (
  input  logic [W-1:0] cnt_i,
  input  logic         carry_i,
  output logic [W-1:0] cnt_o,
  output logic         carry_o
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  always_comb begin
    cnt_o   = cnt_i;
    carry_o = 1'b0;
    if (carry_i) begin
      if (cnt_i == LAST) begin
        cnt_o   = '0;
        carry_o = 1'b1;
      end else begin
        cnt_o = cnt_i + W'(1);
      end
    end
  end
endmodule

// File: rtl/rtc_carry_chain.sv
module rtc_carry_chain #(
  parameter int W          = 8,
  parameter int N          = 5,
  parameter int SEC_LIMIT  = 60,
  parameter int MIN_LIMIT  = 60,
  parameter int HOUR_LIMIT = 24
) (
  input  logic         tick_i,
  input  logic [N*W-1:0] cur_i,
  output logic [N*W-1:0] nxt_o
);
  localparam int STAGES = 3;

  function automatic int stage_limit(input int g);
    case (g)
      0:       return SEC_LIMIT;
      1:       return MIN_LIMIT;
      default: return HOUR_LIMIT;
    endcase
  endfunction

  logic [STAGES:0] carry;
  assign carry[0] = tick_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    rtc_mod_stage #(.W(W), .LIMIT(stage_limit(g))) u_stage (
      .cnt_i   (cur_i[g*W +: W]),
      .carry_i (carry[g]),
      .cnt_o   (nxt_o[g*W +: W]),
      .carry_o (carry[g+1])
    );
  end

  logic [W-1:0] day_lo;
  logic [W-1:0] ctrl;
  logic [W-1:0] day_lo_n;
  logic [W-1:0] ctrl_n;
  logic         day_carry;

  assign day_lo = cur_i[3*W +: W];
  assign ctrl   = cur_i[4*W +: W];

  always_comb begin
    day_lo_n  = day_lo;
    day_carry = 1'b0;
    if (carry[STAGES]) begin
      if (day_lo == {W{1'b1}}) begin
        day_lo_n  = '0;
        day_carry = 1'b1;
      end else begin
        day_lo_n = day_lo + W'(1);
      end
    end
  end

  always_comb begin
    ctrl_n = ctrl;
    if (day_carry) begin
      if (ctrl[rtc_pkg::CTRL_DAYHI_BIT]) begin
        ctrl_n[rtc_pkg::CTRL_DAYHI_BIT] = 1'b0;
        ctrl_n[W-1]                     = ~ctrl[W-1];
      end else begin
        ctrl_n[rtc_pkg::CTRL_DAYHI_BIT] = 1'b1;
      end
    end
  end

  assign nxt_o[3*W +: W] = day_lo_n;
  assign nxt_o[4*W +: W] = ctrl_n;
endmodule

// File: rtl/rtc_reg_bank.sv
module rtc_reg_bank #(
  parameter int W     = 8,
  parameter int N     = 5,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [N*W-1:0]   load_vec_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [W-1:0]     wr_data_i,
  output logic [N*W-1:0]   q_o
);
  logic [N*W-1:0] q_r;
  logic [N*W-1:0] q_n;
  logic           upd_en;

  always_comb begin
    q_n = q_r;
    for (int i = 0; i < N; i++) begin
      if (wr_en_i && (wr_sel_i == SEL_W'(i))) begin
        q_n[i*W +: W] = wr_data_i;
      end else if (load_i) begin
        q_n[i*W +: W] = load_vec_i[i*W +: W];
      end
    end
  end

  assign upd_en = load_i | wr_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (upd_en) begin
      q_r <= q_n;
    end
  end

  assign q_o = q_r;
endmodule

// File: rtl/rtc_shadow_clock.sv
module rtc_shadow_clock #(
  parameter int DATA_W     = 8,
  parameter int SEC_LIMIT  = 60,
  parameter int MIN_LIMIT  = 60,
  parameter int HOUR_LIMIT = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_en,
  input  logic                     snap_stb,
  input  logic                     wr_en,
  input  logic [rtc_pkg::SEL_W-1:0] wr_sel,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [rtc_pkg::SEL_W-1:0] rd_sel,
  output logic [DATA_W-1:0]        rd_data
);
  localparam int N     = rtc_pkg::RTC_REGS;
  localparam int SEL_W = rtc_pkg::SEL_W;
  localparam int VEC_W = N * DATA_W;

  logic             rst_sync_n;
  logic [VEC_W-1:0] live_q;
  logic [VEC_W-1:0] shadow_q;
  logic [VEC_W-1:0] chain_nxt;

  rtc_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  rtc_carry_chain #(
    .W(DATA_W), .N(N),
    .SEC_LIMIT(SEC_LIMIT), .MIN_LIMIT(MIN_LIMIT), .HOUR_LIMIT(HOUR_LIMIT)
  ) u_chain (
    .tick_i (tick_en),
    .cur_i  (live_q),
    .nxt_o  (chain_nxt)
  );

  rtc_reg_bank #(.W(DATA_W), .N(N), .SEL_W(SEL_W)) u_live (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (tick_en),
    .load_vec_i (chain_nxt),
    .wr_en_i    (wr_en),
    .wr_sel_i   (wr_sel),
    .wr_data_i  (wr_data),
    .q_o        (live_q)
  );

  rtc_reg_bank #(.W(DATA_W), .N(N), .SEL_W(SEL_W)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (snap_stb),
    .load_vec_i (live_q),
    .wr_en_i    (wr_en),
    .wr_sel_i   (wr_sel),
    .wr_data_i  (wr_data),
    .q_o        (shadow_q)
  );

  always_comb begin
    rd_data = {DATA_W{1'b1}};
    for (int i = 0; i < N; i++) begin
      if (rd_sel == SEL_W'(i)) begin
        rd_data = shadow_q[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/rtc_shadow_clock_chk.sv
module rtc_shadow_clock_chk #(
  parameter int W          = 8,
  parameter int SEC_LIMIT  = 60,
  parameter int MIN_LIMIT  = 60,
  parameter int HOUR_LIMIT = 24
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick_en,
  input logic           snap_stb,
  input logic           wr_en,
  input logic [2:0]     wr_sel,
  input logic [W-1:0]   wr_data,
  input logic [5*W-1:0] live,
  input logic [5*W-1:0] shadow
);
  function automatic logic [W-1:0] pick(input logic [5*W-1:0] v, input logic [2:0] s);
    logic [W-1:0] r;
    r = '0;
    for (int i = 0; i < 5; i++) begin
      if (s == 3'(i)) r = v[i*W +: W];
    end
    return r;
  endfunction

  logic [W-1:0] sec, mins, hrs, dlo, ctl;
  logic         full_chain;
  assign sec  = live[0*W +: W];
  assign mins = live[1*W +: W];
  assign hrs  = live[2*W +: W];
  assign dlo  = live[3*W +: W];
  assign ctl  = live[4*W +: W];
  assign full_chain = (sec == W'(SEC_LIMIT-1)) && (mins == W'(MIN_LIMIT-1)) &&
                      (hrs == W'(HOUR_LIMIT-1)) && (dlo == {W{1'b1}});

  assert_write_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel < 3'd5) |=> pick(live, $past(wr_sel)) == $past(wr_data));

  assert_write_shadow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel < 3'd5) |=> pick(shadow, $past(wr_sel)) == $past(wr_data));

  assert_snap_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_stb && !wr_en) |=> shadow == $past(live));

  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap_stb && !wr_en) |=> $stable(shadow));

  assert_live_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_en) |=> $stable(live));

  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_en && sec == W'(SEC_LIMIT-1)) |=> live[0*W +: W] == '0);

  assert_wrap_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_en && full_chain && ctl[0])
      |=> (!live[4*W] && (live[5*W-1] != $past(ctl[W-1]))));
endmodule

bind rtc_shadow_clock rtc_shadow_clock_chk #(
  .W(DATA_W), .SEC_LIMIT(SEC_LIMIT), .MIN_LIMIT(MIN_LIMIT), .HOUR_LIMIT(HOUR_LIMIT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .tick_en  (tick_en),
  .snap_stb (snap_stb),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .live     (live_q),
  .shadow   (shadow_q)
);

// File: tb/sim_rtc_shadow_clock.sv
`timescale 1ns/1ps
module sim_rtc_shadow_clock;
  logic       clk;
  logic       rst_n;
  logic       tick_en;
  logic       snap_stb;
  logic       wr_en;
  logic [2:0] wr_sel;
  logic [7:0] wr_data;
  logic [2:0] rd_sel;
  logic [7:0] rd_data;

  int  vectors;
  int  miscompares;
  bit  finished;

  rtc_shadow_clock u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .snap_stb(snap_stb),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic drive(input logic t, input logic s, input logic w,
                       input logic [2:0] sel, input logic [7:0] d);
    tick_en  = t;
    snap_stb = s;
    wr_en    = w;
    wr_sel   = sel;
    wr_data  = d;
    @(negedge clk);
    tick_en  = 1'b0;
    snap_stb = 1'b0;
    wr_en    = 1'b0;
    wr_sel   = 3'd0;
    wr_data  = 8'd0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    drive(1'b0, 1'b0, 1'b1, sel, d);
  endtask

  task automatic tk();
    drive(1'b1, 1'b0, 1'b0, 3'd0, 8'd0);
  endtask

  task automatic snap();
    drive(1'b0, 1'b1, 1'b0, 3'd0, 8'd0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, 3'd0, 8'd0);
  endtask

  task automatic check(input logic [2:0] sel, input logic [7:0] exp, input string req);
    rd_sel = sel;
    #1;
    vectors++;
    if (rd_data !== exp) begin
      miscompares++;
      $display("FAIL %s: index %0d read %02h expected %02h", req, sel, rd_data, exp);
    end
  endtask

  task automatic preset(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                        input logic [7:0] d, input logic [7:0] c);
    wr(3'd0, s); wr(3'd1, m); wr(3'd2, h); wr(3'd3, d); wr(3'd4, c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    vectors = 0; miscompares = 0; finished = 1'b0;
    rst_n = 1'b0; tick_en = 1'b0; snap_stb = 1'b0; wr_en = 1'b0;
    wr_sel = 3'd0; wr_data = 8'd0; rd_sel = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 5; i++) check(3'(i), 8'h00, "R1");

    // R2 / R13 seconds sweep over all codes
    for (int s = 0; s < 256; s++) begin
      preset(8'(s), 8'd0, 8'd0, 8'd0, 8'd0);
      tk(); snap();
      check(3'd0, (s == 59) ? 8'd0 : 8'(s + 1), (s >= 60) ? "R13" : "R2");
      check(3'd1, (s == 59) ? 8'd1 : 8'd0, "R2");
    end

    // R3 minutes sweep with seconds at limit
    for (int m = 0; m < 256; m++) begin
      preset(8'd59, 8'(m), 8'd0, 8'd0, 8'd0);
      tk(); snap();
      check(3'd1, (m == 59) ? 8'd0 : 8'(m + 1), (m >= 60) ? "R13" : "R3");
      check(3'd2, (m == 59) ? 8'd1 : 8'd0, "R3");
      check(3'd0, 8'd0, "R2");
    end

    // R4 hours sweep with lower stages at limit
    for (int h = 0; h < 256; h++) begin
      preset(8'd59, 8'd59, 8'(h), 8'd0, 8'd0);
      tk(); snap();
      check(3'd2, (h == 23) ? 8'd0 : 8'(h + 1), (h >= 24) ? "R13" : "R4");
      check(3'd3, (h == 23) ? 8'd1 : 8'd0, "R4");
    end

    // R5 day low byte sweep
    for (int d = 0; d < 256; d++) begin
      preset(8'd59, 8'd59, 8'd23, 8'(d), 8'd0);
      tk(); snap();
      check(3'd3, (d == 255) ? 8'd0 : 8'(d + 1), "R5");
      check(3'd4, (d == 255) ? 8'd1 : 8'd0, "R5");
      check(3'd2, 8'd0, "R4");
    end

    // R6 control byte sweep with full ripple
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cv;
      logic [7:0] ev;
      cv = 8'(c);
      ev = cv[0] ? ((cv & 8'hFE) ^ 8'h80) : (cv | 8'h01);
      preset(8'd59, 8'd59, 8'd23, 8'hFF, cv);
      tk(); snap();
      check(3'd4, ev, cv[0] ? "R6" : "R5");
      check(3'd3, 8'd0, "R5");
    end

    // R6 natural two-tick ripple
    preset(8'd58, 8'd59, 8'd23, 8'hFF, 8'h01);
    tk(); tk(); snap();
    check(3'd0, 8'd0, "R2");
    check(3'd1, 8'd0, "R3");
    check(3'd2, 8'd0, "R4");
    check(3'd3, 8'd0, "R5");
    check(3'd4, 8'h80, "R6");

    // R7 hold without tick
    preset(8'd5, 8'd6, 8'd7, 8'd8, 8'd0);
    idle(20); snap();
    check(3'd0, 8'd5, "R7");
    check(3'd3, 8'd8, "R7");

    // R8 read port shows snapshot only
    wr(3'd0, 8'd10);
    tk(); tk(); tk();
    check(3'd0, 8'd10, "R8");
    snap();
    check(3'd0, 8'd13, "R8");

    // R9 write updates both copies without a strobe
    wr(3'd2, 8'd17);
    check(3'd2, 8'd17, "R9");
    snap();
    check(3'd2, 8'd17, "R9");

    // R10 write and tick together
    preset(8'd59, 8'd7, 8'd1, 8'd0, 8'd0);
    drive(1'b1, 1'b0, 1'b1, 3'd0, 8'd30);
    snap();
    check(3'd0, 8'd30, "R10");
    check(3'd1, 8'd8, "R10");
    preset(8'd59, 8'd7, 8'd1, 8'd0, 8'd0);
    drive(1'b1, 1'b0, 1'b1, 3'd1, 8'd20);
    snap();
    check(3'd0, 8'd0, "R10");
    check(3'd1, 8'd20, "R10");

    // R11 write and strobe together
    preset(8'd40, 8'd2, 8'd3, 8'd4, 8'd0);
    tk();
    drive(1'b0, 1'b1, 1'b1, 3'd1, 8'd9);
    check(3'd0, 8'd41, "R11");
    check(3'd1, 8'd9, "R11");

    // R12 unused indices
    preset(8'd11, 8'd22, 8'd3, 8'd44, 8'h81);
    wr(3'd5, 8'hAA); wr(3'd6, 8'h00); wr(3'd7, 8'h55);
    snap();
    check(3'd0, 8'd11, "R12");
    check(3'd1, 8'd22, "R12");
    check(3'd2, 8'd3, "R12");
    check(3'd3, 8'd44, "R12");
    check(3'd4, 8'h81, "R12");
    check(3'd5, 8'hFF, "R12");
    check(3'd7, 8'hFF, "R12");

    // R1 reset clears everything again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 5; i++) check(3'(i), 8'h00, "R1");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule